// File: doc/BRIEF.md
# Privilege-Checked System Control Register Bank

This block holds the 32-bit system control registers of a processor core and serves the core's coprocessor move instructions. Each access names a register with four fields: a primary register number, a first opcode, a secondary register number and a second opcode. A privilege flag comes with every access. The block decodes the four fields and applies a permission rule that depends on both the register and the direction. It then returns the register value or updates the register. One cycle after every access it reports whether the access reached an implemented, permitted register.

Barrier and prefetch-flush encodings have no side effect inside the block. A write to one of them is only held in a register, which the core cannot read back. Identification registers are constants. Every other register is plain storage with a defined reset value. The performance counters do not count on their own.

Top module: `sysreg_bank`

## Requirements
- R1: After reset, reads return these values: 0x00054078 at selector (1,0,0,0), 0x0000000F at (1,0,0,1), 0xFFFFFFF0 at (9,0,0,0), 0x00098AA4 at (10,0,2,0), 0x44E048E0 at (10,0,2,1), and zero from every other storage register. Selectors are written (primary, first opcode, secondary, second opcode). After reset, rdata, acc_ok and acc_err are zero.
- R2: A register is chosen only when all four fields match. At (1,0,0,x), second opcode 0, 1 and 2 select three separate registers. Storage registers also sit at (2,0,0,0..2), (3,0,0,0), (5,0,0,0..1), (6,0,0,0..1), (9,0,0,0), (10,0,0,0), (10,0,2,0..1) and (13,0,0,0..4). A privileged write updates only the selected register and is visible to a read issued in the next cycle.
- R3: rdata and the status pulses appear in the cycle after the rd_en strobe. rdata keeps its value in every cycle with no read strobe.
- R4: The identification registers are constants: 0x410FB024 at (0,0,0,0), 0x00000800 at (0,0,0,3), 0x00000111 at (0,0,1,0) and 0x00000001 at (0,0,1,1). They can be read only with privilege, and any write to them is refused.
- R5: The thread register at (13,0,0,2) can be read and written with or without privilege.
- R6: The thread register at (13,0,0,3) can be read without privilege but written only with privilege. An unprivileged write leaves it unchanged.
- R7: Writes to (7,0,10,4), (7,0,10,5) and (7,0,5,4) are accepted with or without privilege. These selectors cannot be read: a read is refused and returns zero.
- R8: Every register not named in R5 to R7 needs privilege. An unprivileged read returns zero and is refused, and an unprivileged write changes nothing.
- R9: A selector that matches no register is refused. A read of it returns zero, and a write to it changes no register.
- R10: Exactly one of acc_ok and acc_err pulses for one cycle after each access. acc_ok means a decoded and permitted access. Neither pulses without a strobe.
- R11: When rd_en and wr_en are high together, only the read is performed and the write is dropped.
- R12: The performance monitor registers at (15,0,12,0..3) are four separate privileged storage registers with reset value zero. They change only when written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| priv | input | 1 | Access is made in a privileged mode |
| prim | input | 4 | Primary register number |
| op1 | input | 3 | First opcode |
| sec | input | 4 | Secondary register number |
| op2 | input | 3 | Second opcode |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| acc_ok | output | 1 | Pulse: access decoded and permitted |
| acc_err | output | 1 | Pulse: access undecoded or not permitted |

## Verification
The hardest case to reach from the ports is a refused write that lands near a live register. An unprivileged write to the user-readable thread register, or a write whose first opcode differs from a real register's by one bit, must leave every register intact. The only way to see this is a later privileged read. The stimulus mixes random selectors, privilege and direction over a long run. A bench model tracks every register, so any stray update shows up on a later read. Directed sequences follow each refused write with an immediate privileged read of the nearby register.

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;
  localparam int DATA_W = 32;
  localparam int PRIM_W = 4;
  localparam int OP1_W  = 3;
  localparam int SEC_W  = 4;
  localparam int OP2_W  = 3;
  localparam int KEY_W  = PRIM_W + OP1_W + SEC_W + OP2_W;
  localparam int NUM_RW = 27;               // writable storage slots
  localparam int NUM_ID = 4;                // constant identification words
  localparam int NUM_SEL = NUM_RW + NUM_ID;
  localparam int IDX_W  = $clog2(NUM_SEL);

  typedef logic [DATA_W-1:0] word_t;
  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [KEY_W-1:0]  key_t;

  // storage slot numbering
  localparam int IX_CTRL  = 0;
  localparam int IX_AUX   = 1;
  localparam int IX_CPAC  = 2;
  localparam int IX_TB0   = 3;
  localparam int IX_TB1   = 4;
  localparam int IX_TBC   = 5;
  localparam int IX_DOM   = 6;
  localparam int IX_DFS   = 7;
  localparam int IX_IFS   = 8;
  localparam int IX_DFA   = 9;
  localparam int IX_WFA   = 10;
  localparam int IX_DCL   = 11;
  localparam int IX_TLL   = 12;
  localparam int IX_PRM   = 13;
  localparam int IX_NRM   = 14;
  localparam int IX_PID   = 15;
  localparam int IX_CTX   = 16;
  localparam int IX_TUSR  = 17;
  localparam int IX_TURO  = 18;
  localparam int IX_TPRV  = 19;
  localparam int IX_PMC   = 20;
  localparam int IX_CYC   = 21;
  localparam int IX_EV0   = 22;
  localparam int IX_EV1   = 23;
  localparam int IX_BDSB  = 24;
  localparam int IX_BDMB  = 25;
  localparam int IX_BPFF  = 26;
  localparam int IX_ID0   = 27;

  typedef struct packed {
    logic rd_dec;
    logic wr_dec;
    logic rd_user;
    logic wr_user;
    idx_t idx;
  } sel_info_t;

  function automatic sel_info_t mk_info(int ix, logic r, logic w, logic ru, logic wu);
    sel_info_t s;
    s.rd_dec  = r;
    s.wr_dec  = w;
    s.rd_user = ru;
    s.wr_user = wu;
    s.idx     = idx_t'(ix);
    return s;
  endfunction

  function automatic word_t reset_word(int i);
    case (i)
      IX_CTRL: return 32'h0005_4078;
      IX_AUX:  return 32'h0000_000F;
      IX_DCL:  return 32'hFFFF_FFF0;
      IX_PRM:  return 32'h0009_8AA4;
      IX_NRM:  return 32'h44E0_48E0;
      default: return '0;
    endcase
  endfunction

  function automatic word_t ident_word(int i);
    case (i)
      0:       return 32'h410F_B024;
      1:       return 32'h0000_0800;
      2:       return 32'h0000_0111;
      default: return 32'h0000_0001;
    endcase
  endfunction
endpackage

// File: rtl/sysreg_decode.sv
module sysreg_decode
  import sysreg_pkg::*;
(
  input  logic [PRIM_W-1:0] prim,
  input  logic [OP1_W-1:0]  op1,
  input  logic [SEC_W-1:0]  sec,
  input  logic [OP2_W-1:0]  op2,
  output sel_info_t         info
);
  key_t key;
  assign key = {prim, op1, sec, op2};

  always_comb begin
    info = '0;
    case (key)
      {4'd1, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_CTRL, 1'b1, 1'b1, 1'b0, 1'b0);
      {4'd1, 3'd0, 4'd0, 3'd1}:   info = mk_info(IX_AUX,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd1, 3'd0, 4'd0, 3'd2}:   info = mk_info(IX_CPAC, 1'b1, 1'b1, 1'b0, 1'b0);
      {4'd2, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_TB0,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd2, 3'd0, 4'd0, 3'd1}:   info = mk_info(IX_TB1,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd2, 3'd0, 4'd0, 3'd2}:   info = mk_info(IX_TBC,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd3, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_DOM,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd5, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_DFS,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd5, 3'd0, 4'd0, 3'd1}:   info = mk_info(IX_IFS,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd6, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_DFA,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd6, 3'd0, 4'd0, 3'd1}:   info = mk_info(IX_WFA,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd9, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_DCL,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd10, 3'd0, 4'd0, 3'd0}:  info = mk_info(IX_TLL,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd10, 3'd0, 4'd2, 3'd0}:  info = mk_info(IX_PRM,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd10, 3'd0, 4'd2, 3'd1}:  info = mk_info(IX_NRM,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd13, 3'd0, 4'd0, 3'd0}:  info = mk_info(IX_PID,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd13, 3'd0, 4'd0, 3'd1}:  info = mk_info(IX_CTX,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd13, 3'd0, 4'd0, 3'd2}:  info = mk_info(IX_TUSR, 1'b1, 1'b1, 1'b1, 1'b1);
      {4'd13, 3'd0, 4'd0, 3'd3}:  info = mk_info(IX_TURO, 1'b1, 1'b1, 1'b1, 1'b0);
      {4'd13, 3'd0, 4'd0, 3'd4}:  info = mk_info(IX_TPRV, 1'b1, 1'b1, 1'b0, 1'b0);
      {4'd15, 3'd0, 4'd12, 3'd0}: info = mk_info(IX_PMC,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd15, 3'd0, 4'd12, 3'd1}: info = mk_info(IX_CYC,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd15, 3'd0, 4'd12, 3'd2}: info = mk_info(IX_EV0,  1'b1, 1'b1, 1'b0, 1'b0);
      {4'd15, 3'd0, 4'd12, 3'd3}: info = mk_info(IX_EV1,  1'b1, 1'b1, 1'b0, 1'b0);
      // barrier and prefetch-flush sinks: write only, open to user mode
      {4'd7, 3'd0, 4'd10, 3'd4}:  info = mk_info(IX_BDSB, 1'b0, 1'b1, 1'b0, 1'b1);
      {4'd7, 3'd0, 4'd10, 3'd5}:  info = mk_info(IX_BDMB, 1'b0, 1'b1, 1'b0, 1'b1);
      {4'd7, 3'd0, 4'd5, 3'd4}:   info = mk_info(IX_BPFF, 1'b0, 1'b1, 1'b0, 1'b1);
      // identification constants: privileged read only
      {4'd0, 3'd0, 4'd0, 3'd0}:   info = mk_info(IX_ID0,     1'b1, 1'b0, 1'b0, 1'b0);
      {4'd0, 3'd0, 4'd0, 3'd3}:   info = mk_info(IX_ID0 + 1, 1'b1, 1'b0, 1'b0, 1'b0);
      {4'd0, 3'd0, 4'd1, 3'd0}:   info = mk_info(IX_ID0 + 2, 1'b1, 1'b0, 1'b0, 1'b0);
      {4'd0, 3'd0, 4'd1, 3'd1}:   info = mk_info(IX_ID0 + 3, 1'b1, 1'b0, 1'b0, 1'b0);
      default:                    info = '0;
    endcase
  end
endmodule

// File: rtl/sysreg_access.sv
module sysreg_access
  import sysreg_pkg::*;
(
  input  logic      rd_en,
  input  logic      wr_en,
  input  logic      priv,
  input  sel_info_t info,
  output logic      rd_go,
  output logic      wr_go,
  output logic      ok_nxt,
  output logic      err_nxt
);
  logic rd_act;
  logic wr_act;

  // a read strobe wins over a simultaneous write strobe
  assign rd_act  = rd_en;
  assign wr_act  = wr_en & ~rd_en;
  assign rd_go   = rd_act & info.rd_dec & (priv | info.rd_user);
  assign wr_go   = wr_act & info.wr_dec & (priv | info.wr_user);
  assign ok_nxt  = rd_go | wr_go;
  assign err_nxt = (rd_act | wr_act) & ~(rd_go | wr_go);
endmodule

// File: rtl/sysreg_store.sv
module sysreg_store
  import sysreg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_go,
  input  idx_t  idx,
  input  word_t wdata,
  output word_t rd_val
);
  word_t regs [NUM_RW];

  for (genvar i = 0; i < NUM_RW; i++) begin : g_slot
    logic  slot_en;
    word_t slot_nxt;
    assign slot_en  = wr_go & (idx == idx_t'(i));
    assign slot_nxt = slot_en ? wdata : regs[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs[i] <= reset_word(i);
      else        regs[i] <= slot_nxt;
    end
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_RW; i++) begin
      if (idx == idx_t'(i)) rd_val = regs[i];
    end
    for (int j = 0; j < NUM_ID; j++) begin
      if (idx == idx_t'(NUM_RW + j)) rd_val = ident_word(j);
    end
  end
endmodule

// File: rtl/sysreg_bank.sv
module sysreg_bank
  import sysreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic              priv,
  input  logic [PRIM_W-1:0] prim,
  input  logic [OP1_W-1:0]  op1,
  input  logic [SEC_W-1:0]  sec,
  input  logic [OP2_W-1:0]  op2,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              acc_ok,
  output logic              acc_err
);
  sel_info_t info;
  logic      rd_go;
  logic      wr_go;
  logic      ok_nxt;
  logic      err_nxt;
  word_t     rd_val;
  word_t     rdata_q;
  word_t     rdata_nxt;
  logic      rdata_en;
  logic      ok_q;
  logic      err_q;

  sysreg_decode u_dec (
    .prim (prim),
    .op1  (op1),
    .sec  (sec),
    .op2  (op2),
    .info (info)
  );

  sysreg_access u_acc (
    .rd_en   (rd_en),
    .wr_en   (wr_en),
    .priv    (priv),
    .info    (info),
    .rd_go   (rd_go),
    .wr_go   (wr_go),
    .ok_nxt  (ok_nxt),
    .err_nxt (err_nxt)
  );

  sysreg_store u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_go  (wr_go),
    .idx    (info.idx),
    .wdata  (wdata),
    .rd_val (rd_val)
  );

  // next-state: refused reads load zero, idle cycles hold
  assign rdata_en  = rd_en;
  assign rdata_nxt = rd_go ? rd_val : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (rdata_en) rdata_q <= rdata_nxt;
      ok_q  <= ok_nxt;
      err_q <= err_nxt;
    end
  end

  assign rdata   = rdata_q;
  assign acc_ok  = ok_q;
  assign acc_err = err_q;
endmodule

// File: rtl/sysreg_bank_chk.sv
module sysreg_bank_chk
  import sysreg_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic              wr_en,
  input logic              priv,
  input logic [PRIM_W-1:0] prim,
  input logic [OP1_W-1:0]  op1,
  input logic [SEC_W-1:0]  sec,
  input logic [OP2_W-1:0]  op2,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic              acc_ok,
  input logic              acc_err
);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));

  p_user_ident_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !priv && prim == 4'd0) |=> (acc_err && rdata == '0));

  p_user_thread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !priv && prim == 4'd13 && op1 == 3'd0 && sec == 4'd0 && op2 == 3'd2) |=> acc_ok);

  p_ro_thread_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && !priv && prim == 4'd13 && op1 == 3'd0 && sec == 4'd0 && op2 == 3'd3)
    |=> acc_err);

  p_barrier_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && prim == 4'd7 && op1 == 3'd0 && sec == 4'd10 && op2 == 3'd4) |=> acc_ok);

  p_user_ctrl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !priv && prim == 4'd1) |=> (acc_err && rdata == '0));

  p_one_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) |=> (acc_ok ^ acc_err));

  p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_ok || acc_err) |-> $past(rd_en || wr_en));
endmodule

bind sysreg_bank sysreg_bank_chk u_chk (.*);

// File: tb/sysreg_bank_tb.sv
module sysreg_bank_tb;
  logic        clk;
  logic        rst_n;
  logic        rd_en;
  logic        wr_en;
  logic        priv;
  logic [3:0]  prim;
  logic [2:0]  op1;
  logic [3:0]  sec;
  logic [2:0]  op2;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        acc_ok;
  logic        acc_err;

  int errors = 0;
  int checks = 0;
  logic [31:0] mdl [31];
  logic [31:0] exp_rd;

  sysreg_bank u_dut (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .priv(priv),
    .prim(prim), .op1(op1), .sec(sec), .op2(op2), .wdata(wdata),
    .rdata(rdata), .acc_ok(acc_ok), .acc_err(acc_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  // selector table from the requirements: codes 0..23 storage, 24..26 sinks, 27..30 ids
  function automatic logic [13:0] sel_of(int k);
    case (k)
      0: return {4'd1,3'd0,4'd0,3'd0};    1: return {4'd1,3'd0,4'd0,3'd1};
      2: return {4'd1,3'd0,4'd0,3'd2};    3: return {4'd2,3'd0,4'd0,3'd0};
      4: return {4'd2,3'd0,4'd0,3'd1};    5: return {4'd2,3'd0,4'd0,3'd2};
      6: return {4'd3,3'd0,4'd0,3'd0};    7: return {4'd5,3'd0,4'd0,3'd0};
      8: return {4'd5,3'd0,4'd0,3'd1};    9: return {4'd6,3'd0,4'd0,3'd0};
      10: return {4'd6,3'd0,4'd0,3'd1};   11: return {4'd9,3'd0,4'd0,3'd0};
      12: return {4'd10,3'd0,4'd0,3'd0};  13: return {4'd10,3'd0,4'd2,3'd0};
      14: return {4'd10,3'd0,4'd2,3'd1};  15: return {4'd13,3'd0,4'd0,3'd0};
      16: return {4'd13,3'd0,4'd0,3'd1};  17: return {4'd13,3'd0,4'd0,3'd2};
      18: return {4'd13,3'd0,4'd0,3'd3};  19: return {4'd13,3'd0,4'd0,3'd4};
      20: return {4'd15,3'd0,4'd12,3'd0}; 21: return {4'd15,3'd0,4'd12,3'd1};
      22: return {4'd15,3'd0,4'd12,3'd2}; 23: return {4'd15,3'd0,4'd12,3'd3};
      24: return {4'd7,3'd0,4'd10,3'd4};  25: return {4'd7,3'd0,4'd10,3'd5};
      26: return {4'd7,3'd0,4'd5,3'd4};   27: return {4'd0,3'd0,4'd0,3'd0};
      28: return {4'd0,3'd0,4'd0,3'd3};   29: return {4'd0,3'd0,4'd1,3'd0};
      default: return {4'd0,3'd0,4'd1,3'd1};
    endcase
  endfunction

  function automatic int lookup(logic [13:0] key);
    for (int k = 0; k < 31; k++) if (sel_of(k) == key) return k;
    return -1;
  endfunction

  function automatic bit may_read(int k, bit p);
    if (k < 0 || (k >= 24 && k <= 26)) return 0;
    return p || k == 17 || k == 18;
  endfunction

  function automatic bit may_write(int k, bit p);
    if (k < 0 || k >= 27) return 0;
    return p || k == 17 || (k >= 24 && k <= 26);
  endfunction

  function automatic string tag_of(bit rd, bit wr, bit p, int k);
    if (k < 0) return "R9";
    if (rd && wr) return "R11";
    if (k >= 27) return "R4";
    if (k == 17) return "R5";
    if (k == 18) return "R6";
    if (k >= 24 && k <= 26) return "R7";
    if (k >= 20 && k <= 23) return "R12";
    if (!p) return "R8";
    return "R2";
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 31; k++) mdl[k] = 32'h0;
    mdl[0] = 32'h0005_4078; mdl[1] = 32'h0000_000F; mdl[11] = 32'hFFFF_FFF0;
    mdl[13] = 32'h0009_8AA4; mdl[14] = 32'h44E0_48E0;
    mdl[27] = 32'h410F_B024; mdl[28] = 32'h0000_0800;
    mdl[29] = 32'h0000_0111; mdl[30] = 32'h0000_0001;
    exp_rd = 32'h0;
  endtask

  // one access; inputs change at negedge, results sampled at the following negedge
  task automatic acc(bit rd, bit wr, bit p, logic [13:0] key, logic [31:0] wd, string tag);
    int  k;
    bit  good;
    k = lookup(key);
    @(negedge clk);
    rd_en = rd; wr_en = wr; priv = p; wdata = wd;
    {prim, op1, sec, op2} = key;
    if (rd) begin
      good = may_read(k, p);
      exp_rd = good ? mdl[k] : 32'h0;
    end else begin
      good = wr && may_write(k, p);
      if (good) mdl[k] = wd;
    end
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(tag, "rdata", rdata, exp_rd);
    if (rd || wr) begin
      check(tag, "acc_ok", {31'b0, acc_ok}, {31'b0, good});
      check(tag, "acc_err", {31'b0, acc_err}, {31'b0, !good});
    end else begin
      check("R10", "acc_ok idle", {31'b0, acc_ok}, 32'h0);
      check("R10", "acc_err idle", {31'b0, acc_err}, 32'h0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rd_en = 1'b0; wr_en = 1'b0; priv = 1'b0;
    prim = '0; op1 = '0; sec = '0; op2 = '0; wdata = '0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", "rdata in reset", rdata, 32'h0);
    check("R1", "acc_ok in reset", {31'b0, acc_ok}, 32'h0);
    check("R1", "acc_err in reset", {31'b0, acc_err}, 32'h0);
    rst_n = 1'b1;

    // R1: reset values of every readable selector
    for (int k = 0; k < 31; k++) if (may_read(k, 1)) acc(1, 0, 1, sel_of(k), 0, "R1");

    // R2: three neighbours at (1,0,0,x) are distinct
    acc(0, 1, 1, sel_of(0), 32'hA5A5_0001, "R2");
    acc(0, 1, 1, sel_of(1), 32'hA5A5_0002, "R2");
    acc(0, 1, 1, sel_of(2), 32'hA5A5_0003, "R2");
    acc(1, 0, 1, sel_of(0), 0, "R2");
    acc(1, 0, 1, sel_of(1), 0, "R2");
    acc(1, 0, 1, sel_of(2), 0, "R2");
    // R3: idle cycles keep rdata
    acc(0, 0, 1, sel_of(5), 0, "R3");
    acc(0, 0, 0, sel_of(9), 0, "R3");
    // R4: identification words
    acc(1, 0, 0, sel_of(27), 0, "R4");
    acc(0, 1, 1, sel_of(27), 32'hDEAD_BEEF, "R4");
    acc(1, 0, 1, sel_of(27), 0, "R4");
    // R5: user thread register
    acc(0, 1, 0, sel_of(17), 32'h1234_5678, "R5");
    acc(1, 0, 0, sel_of(17), 0, "R5");
    // R6: read-only-for-user thread register
    acc(0, 1, 0, sel_of(18), 32'h0BAD_0BAD, "R6");
    acc(1, 0, 1, sel_of(18), 0, "R6");
    acc(0, 1, 1, sel_of(18), 32'h7777_1111, "R6");
    acc(1, 0, 0, sel_of(18), 0, "R6");
    // R7: barrier sinks
    acc(0, 1, 0, sel_of(24), 32'h1, "R7");
    acc(0, 1, 0, sel_of(26), 32'h2, "R7");
    acc(1, 0, 1, sel_of(25), 0, "R7");
    // R8: privileged-only registers refuse user access
    acc(1, 0, 0, sel_of(0), 0, "R8");
    acc(0, 1, 0, sel_of(0), 32'hFFFF_FFFF, "R8");
    acc(1, 0, 1, sel_of(0), 0, "R8");
    // R9: undecoded selectors, one bit away from a real register
    acc(1, 0, 1, {4'd4,3'd0,4'd0,3'd0}, 0, "R9");
    acc(0, 1, 1, {4'd1,3'd1,4'd0,3'd0}, 32'h5555_5555, "R9");
    acc(1, 0, 1, sel_of(0), 0, "R9");
    // R11: read wins over a simultaneous write
    acc(1, 1, 1, sel_of(6), 32'hCAFE_F00D, "R11");
    acc(1, 0, 1, sel_of(6), 0, "R11");
    // R12: performance monitor slots
    for (int k = 20; k < 24; k++) acc(0, 1, 1, sel_of(k), 32'h0100_0000 + k, "R12");
    for (int k = 20; k < 24; k++) acc(1, 0, 1, sel_of(k), 0, "R12");

    // constrained random mix
    void'($urandom(32'd20240611));
    for (int n = 0; n < 3000; n++) begin
      logic [13:0] key;
      bit rd, wr, p;
      int k;
      if ($urandom_range(9) < 7) key = sel_of($urandom_range(30));
      else key = 14'($urandom);
      rd = $urandom_range(1);
      wr = $urandom_range(3) != 0;
      p  = $urandom_range(1);
      k  = lookup(key);
      acc(rd, wr, p, key, $urandom, tag_of(rd, wr, p, k));
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule